// File: doc/BRIEF.md
# USB Device Event Status Register

This block collects the interrupt events of a small USB device controller into one 32-bit status word. The controller has a control endpoint and a parameterized set of general endpoints, each with an OUT and an IN direction. Every direction has its own sticky status bit. The endpoint engines raise single-cycle event pulses, and a pulse sets the matching bit.

A direction's bit sets when its transfer completes. Completion means the byte count reached zero or software asked for a skip; for the general endpoints it shows up as the hardware dropping the direction's Active flag. A NAK sent on a direction also sets its bit, but only while the matching NAK-interrupt enable is on. The control endpoint has separate enables for OUT and for IN. All general OUT directions share one enable, and all general IN directions share another.

Two more bits are hardware driven. A frame bit is set by an internal millisecond timer, which runs only while the bus-power-debounced and connected inputs are both high. A device bit is set by a summary input that reports a pending device-state change. Software reads the word and clears bits by writing ones. The interrupt line is high whenever any bit is set.

Top module: `usb_evt_status`

## Requirements
- R1: After reset the status word reads 0x0000_0000 and the interrupt line is low.
- R2: Bit map: bit 0 is control OUT and bit 1 is control IN. General endpoint k (0-based) uses bit 2+2k for OUT and bit 3+2k for IN. Bit 30 is the frame bit and bit 31 is the device bit. All other bits always read 0.
- R3: A write with a one in a bit position clears that bit on the clock edge that samples the write. Bits written with zero keep their value.
- R4: A completion pulse on a direction sets its bit at the next clock edge. For the control endpoint the pulse means byte count zero or skip; for a general endpoint it means the Active flag was cleared by hardware.
- R5: A successful SETUP reception on the control endpoint sets bit 0.
- R6: A NAK pulse sets a direction's bit only when its enable is on. The control OUT and control IN enables are separate. One shared enable covers all general OUT directions and another covers all general IN directions.
- R7: While both the bus-power-debounced and connected inputs are high, the frame bit sets on the CLKS_PER_MS-th clock edge of continuous gating and then once every CLKS_PER_MS edges. Whenever either input is low the timer is held at zero and the frame bit does not set.
- R8: A high device-change summary input sets bit 31.
- R9: If a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up at 1.
- R10: The interrupt output is 1 exactly when the status word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_out_done | input | 1 | Control OUT byte count zero or skip |
| ctl_setup_ok | input | 1 | Control SETUP packet received without error |
| ctl_out_nak | input | 1 | NAK sent on control OUT |
| ctl_in_done | input | 1 | Control IN byte count zero or skip |
| ctl_in_nak | input | 1 | NAK sent on control IN |
| gen_out_done | input | GEN_EPS | Per-endpoint OUT Active flag cleared by hardware |
| gen_out_nak | input | GEN_EPS | Per-endpoint NAK sent on OUT |
| gen_in_done | input | GEN_EPS | Per-endpoint IN Active flag cleared by hardware |
| gen_in_nak | input | GEN_EPS | Per-endpoint NAK sent on IN |
| nak_en_ctl_out | input | 1 | NAK interrupt enable, control OUT |
| nak_en_ctl_in | input | 1 | NAK interrupt enable, control IN |
| nak_en_gen_out | input | 1 | NAK interrupt enable shared by general OUT directions |
| nak_en_gen_in | input | 1 | NAK interrupt enable shared by general IN directions |
| vbus_ok | input | 1 | Debounced bus power present |
| dev_connected | input | 1 | Device connect state |
| dev_chg_any | input | 1 | Any device status change pending |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, ones clear bits |
| rd_data | output | 32 | Current status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CLKS_PER_MS set to 10 and GEN_EPS left at 4. With the short timer period, the exact edge on which the frame bit first sets can be checked, along with the restart after the gate drops and the gate-low case, all within a few dozen cycles. With four general endpoints, bits 2 to 9 are filled, so the bench can confirm that bits 10 to 29 stay zero even when every event input is driven at once.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned CTL_OUT_B = 0;
   localparam int unsigned CTL_IN_B  = 1;
   localparam int unsigned GEN_BASE  = 2;
   localparam int unsigned FRAME_B   = 30;
   localparam int unsigned DEVCHG_B  = 31;
endpackage

// File: rtl/usb_evt_sticky.sv
module usb_evt_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R3
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/usb_evt_ms_timer.sv
module usb_evt_ms_timer #(
   parameter int unsigned CLKS_PER_MS = 48000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic tick_o
);
   localparam int unsigned CNT_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_MS - 1);

   generate
      if (CLKS_PER_MS < 2) begin : g_bad_period
         $error("CLKS_PER_MS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign tick_o = gate_i && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!gate_i) cnt <= '0;
      else if (tick_o)  cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   // R7
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_i |=> (cnt == '0));
   // R7
   tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> gate_i);
   // R7
   tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt == '0));
endmodule

// File: rtl/usb_evt_status.sv
module usb_evt_status
   import usb_evt_pkg::*;
#(
   parameter int unsigned GEN_EPS     = 4,
   parameter int unsigned CLKS_PER_MS = 48000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_out_done,
   input  logic               ctl_setup_ok,
   input  logic               ctl_out_nak,
   input  logic               ctl_in_done,
   input  logic               ctl_in_nak,
   input  logic [GEN_EPS-1:0] gen_out_done,
   input  logic [GEN_EPS-1:0] gen_out_nak,
   input  logic [GEN_EPS-1:0] gen_in_done,
   input  logic [GEN_EPS-1:0] gen_in_nak,
   input  logic               nak_en_ctl_out,
   input  logic               nak_en_ctl_in,
   input  logic               nak_en_gen_out,
   input  logic               nak_en_gen_in,
   input  logic               vbus_ok,
   input  logic               dev_connected,
   input  logic               dev_chg_any,
   input  logic               wr_en,
   input  logic [WORD_W-1:0]  wr_data,
   output logic [WORD_W-1:0]  rd_data,
   output logic               irq
);
   localparam int unsigned LAST_EP_B = GEN_BASE + 2 * GEN_EPS - 1;

   generate
      if (GEN_EPS < 1 || LAST_EP_B >= FRAME_B) begin : g_bad_eps
         $error("GEN_EPS out of range for the status word");
      end
   endgenerate

   logic              frame_tick;
   logic [WORD_W-1:0] set_vec;
   logic [WORD_W-1:0] clr_vec;

   usb_evt_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .gate_i (vbus_ok & dev_connected),
      .tick_o (frame_tick)
   );

   always_comb begin
      set_vec            = '0;
      set_vec[CTL_OUT_B] = ctl_out_done | ctl_setup_ok | (ctl_out_nak & nak_en_ctl_out);
      set_vec[CTL_IN_B]  = ctl_in_done | (ctl_in_nak & nak_en_ctl_in);
      for (int k = 0; k < GEN_EPS; k++) begin
         set_vec[GEN_BASE + 2*k]     = gen_out_done[k] | (gen_out_nak[k] & nak_en_gen_out);
         set_vec[GEN_BASE + 2*k + 1] = gen_in_done[k]  | (gen_in_nak[k]  & nak_en_gen_in);
      end
      set_vec[FRAME_B]   = frame_tick;
      set_vec[DEVCHG_B]  = dev_chg_any;
   end

   assign clr_vec = wr_en ? wr_data : '0;

   genvar b;
   generate
      for (b = 0; b < WORD_W; b++) begin : g_bit
         if (b <= LAST_EP_B || b >= FRAME_B) begin : g_impl
            usb_evt_sticky u_bit (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (set_vec[b]),
               .clr_i (clr_vec[b]),
               .q_o   (rd_data[b])
            );
         end else begin : g_rsvd
            assign rd_data[b] = 1'b0;
         end
      end
   endgenerate

   assign irq = |rd_data;

   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> irq);
   // R8
   devchg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_chg_any |=> rd_data[DEVCHG_B]);
   // R5
   setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_setup_ok |=> rd_data[CTL_OUT_B]);
endmodule

// File: tb/tb_usb_evt_status.sv
module tb_usb_evt_status;
   localparam int unsigned EPS = 4;
   localparam int unsigned PER = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ctl_out_done = 0, ctl_setup_ok = 0, ctl_out_nak = 0;
   logic           ctl_in_done = 0, ctl_in_nak = 0;
   logic [EPS-1:0] gen_out_done = '0, gen_out_nak = '0, gen_in_done = '0, gen_in_nak = '0;
   logic           nak_en_ctl_out = 0, nak_en_ctl_in = 0, nak_en_gen_out = 0, nak_en_gen_in = 0;
   logic           vbus_ok = 0, dev_connected = 0, dev_chg_any = 0;
   logic           wr_en = 0;
   logic [31:0]    wr_data = '0;
   logic [31:0]    rd_data;
   logic           irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   usb_evt_status #(.GEN_EPS(EPS), .CLKS_PER_MS(PER)) dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle_inputs();
      ctl_out_done = 0; ctl_setup_ok = 0; ctl_out_nak = 0;
      ctl_in_done = 0; ctl_in_nak = 0;
      gen_out_done = '0; gen_out_nak = '0; gen_in_done = '0; gen_in_nak = '0;
      dev_chg_any = 0; wr_en = 0; wr_data = '0;
   endtask

   task automatic clear_all();
      wr_en = 1; wr_data = '1; step(); idle_inputs();
   endtask

   task automatic t_reset();
      chk("R1 status", rd_data, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_done_events();
      ctl_out_done = 1; step(); idle_inputs();
      chk("R4 ctl out done", rd_data, 32'h1);
      chk("R10 irq high", {31'b0, irq}, 32'h1);
      clear_all();
      ctl_in_done = 1; gen_out_done[2] = 1; gen_in_done[3] = 1; step(); idle_inputs();
      chk("R4 R2 mixed done", rd_data, 32'h0000_0242);
      clear_all();
      chk("R10 irq low", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_setup();
      ctl_setup_ok = 1; step(); idle_inputs();
      chk("R5 setup", rd_data, 32'h1);
      clear_all();
   endtask

   task automatic t_nak();
      ctl_out_nak = 1; ctl_in_nak = 1; gen_out_nak = '1; gen_in_nak = '1; step(); idle_inputs();
      chk("R6 nak disabled", rd_data, 32'h0);
      nak_en_ctl_in = 1;
      ctl_out_nak = 1; ctl_in_nak = 1; step(); idle_inputs();
      chk("R6 ctl in enable only", rd_data, 32'h2);
      clear_all();
      nak_en_ctl_in = 0; nak_en_gen_out = 1;
      gen_out_nak = 4'b1001; gen_in_nak = 4'b1111; step(); idle_inputs();
      chk("R6 gen out shared", rd_data, 32'h0000_0104);
      clear_all();
      nak_en_gen_out = 0; nak_en_gen_in = 1; nak_en_ctl_out = 1;
      gen_in_nak = 4'b0010; ctl_out_nak = 1; step(); idle_inputs();
      chk("R6 gen in and ctl out", rd_data, 32'h0000_0021);
      nak_en_gen_in = 0; nak_en_ctl_out = 0;
      clear_all();
   endtask

   task automatic t_w1c();
      gen_out_done = '1; gen_in_done = '1; ctl_out_done = 1; ctl_in_done = 1; dev_chg_any = 1;
      step(); idle_inputs();
      chk("R2 all set, reserved zero", rd_data, 32'h8000_03FF);
      wr_en = 1; wr_data = 32'h0000_0000; step(); idle_inputs();
      chk("R3 zero write no effect", rd_data, 32'h8000_03FF);
      wr_en = 1; wr_data = 32'h8000_0155; step(); idle_inputs();
      chk("R3 partial clear", rd_data, 32'h0000_02AA);
      clear_all();
   endtask

   task automatic t_collide();
      gen_in_done[0] = 1; step(); idle_inputs();
      gen_in_done[0] = 1; wr_en = 1; wr_data = 32'h0000_0008; step(); idle_inputs();
      chk("R9 set beats clear", rd_data, 32'h0000_0008);
      clear_all();
   endtask

   task automatic t_devchg();
      dev_chg_any = 1; step(); idle_inputs();
      chk("R8 device bit", rd_data, 32'h8000_0000);
      clear_all();
   endtask

   task automatic t_frame();
      dev_connected = 1;
      repeat (3 * PER) step();
      chk("R7 no tick without vbus", rd_data, 32'h0);
      vbus_ok = 1;
      repeat (PER - 1) step();
      chk("R7 before period", rd_data, 32'h0);
      step();
      chk("R7 first tick", rd_data, 32'h4000_0000);
      wr_en = 1; wr_data = 32'h4000_0000; step(); idle_inputs();
      repeat (PER - 2) step();
      chk("R7 cleared mid period", rd_data, 32'h0);
      step();
      chk("R7 periodic tick", rd_data, 32'h4000_0000);
      clear_all();
      repeat (5) step();
      dev_connected = 0; step();
      dev_connected = 1;
      repeat (PER - 1) step();
      chk("R7 restart after gate drop", rd_data, 32'h0);
      step();
      chk("R7 tick after restart", rd_data, 32'h4000_0000);
      vbus_ok = 0; dev_connected = 0;
      clear_all();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      #1;
      t_reset();
      repeat (2) step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_done_events();
      t_setup();
      t_nak();
      t_w1c();
      t_collide();
      t_devchg();
      t_frame();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule